// File: doc/BRIEF.md
# Character Display Command Front End

This block accepts byte-wide writes from a host processor and turns them into the control actions of a character display controller. Instruction writes choose one of three memories: glyph code RAM, attribute RAM or glyph pattern RAM. They also load a shared address counter, set the step direction, and set the line mode and common-line count. Data writes go to whichever memory was chosen last, at the current counter value. After each data write the counter steps up or down, and it wraps at boundaries that depend on the selected memory and the line mode.

Every accepted write starts a fixed execution window. During that window a busy bit is set, and the block drops any further write. The host learns the busy state and the counter value from a status byte that is always driven.

The host side is a valid/ready port. `host_ready` is tied high, so the block never applies back-pressure. A write offered while busy completes its handshake but has no effect. The host is expected to poll the busy bit before it issues the next write. A status read (`host_rs`=0, `host_rw`=1) has no side effect. Data reads (`host_rs`=1, `host_rw`=1) are outside this block and are also ignored.

Top module: `lcdc_cmd_front`

## Requirements
- R1: After reset the status byte is 0x00, code RAM is the target, stepping is upward, one-line mode is active and `com_count` is 8.
- R2: An instruction byte with bit 7 set loads bits 6..0 into the counter and makes code RAM the target.
- R3: An instruction byte of the form 01xxxxxx loads bits 5..0 into the counter and makes pattern RAM the target.
- R4: An instruction byte of the form 0001xxxx loads bits 3..0 into the counter and makes attribute RAM the target.
- R5: On an accepted data write (`host_rs`=1, `host_rw`=0), exactly one strobe pulses in the next cycle, for the target RAM (code, attribute or pattern). At the same time `ram_addr` holds the counter value from before the write and `ram_wdata` holds the bus byte. The target stays selected across any instruction that is not an address load.
- R6: An instruction byte of the form 000001xx sets the step direction from bit 1 (1 = up, 0 = down). The counter steps in that direction after every data write.
- R7: In one-line mode the code counter steps up from 0x4F to 0x00 and down from 0x00 to 0x4F.
- R8: In two-line mode the code counter steps up from 0x27 to 0x40 and from 0x67 to 0x00. It steps down from 0x40 to 0x27 and from 0x00 to 0x67.
- R9: The pattern counter wraps within 6 bits (0x3F and 0x00), and the attribute counter wraps within 4 bits (0x0F and 0x00).
- R10: An instruction byte of the form 001xxxxx sets the line mode from bit 3 (1 = two lines, shown on `two_line`) and an extra common row from bit 2. `com_count` then reads 8, 9, 16 or 17.
- R11: Every accepted write sets status bit 7 from the next cycle for exactly 10 cycles. A status read does not set it.
- R12: A write offered while busy is dropped. It produces no strobe and changes neither the counter, the target nor the modes. `host_ready` is always 1.
- R13: `status_rdata` carries the busy bit on bit 7 and the counter on bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host transfer valid |
| host_ready | output | 1 | Always 1; writes offered while busy are discarded |
| host_rs | input | 1 | 0 = instruction/status, 1 = RAM data |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Host write byte |
| status_rdata | output | 8 | {busy, address counter} |
| code_we | output | 1 | Code RAM write strobe |
| attr_we | output | 1 | Attribute RAM write strobe |
| pat_we | output | 1 | Pattern RAM write strobe |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| two_line | output | 1 | Two-line mode active |
| com_count | output | 5 | Number of common lines driven |

## Verification
The wrap assertions take for granted that the host loads code addresses only inside the legal range for the current line mode. Stepping from an illegal address is simple arithmetic and is not checked. The assertions also assume that `host_rs`, `host_rw` and `host_wdata` are settled whenever `host_valid` is high. The stimulus loads only legal addresses in each sweep. It changes inputs only between clock edges and waits out the busy window before each new write, except in the cases that deliberately write into that window.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  typedef enum logic [1:0] {
    TGT_CODE = 2'd0,
    TGT_ATTR = 2'd1,
    TGT_PAT  = 2'd2
  } ram_tgt_e;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_ENTRY    = 3'd1,
    OP_FUNC     = 3'd2,
    OP_ATTR_ADR = 3'd3,
    OP_PAT_ADR  = 3'd4,
    OP_CODE_ADR = 3'd5
  } op_e;

  localparam int HOST_W = 8;
endpackage

// File: rtl/lcdc_op_decode.sv
module lcdc_op_decode
  import lcdc_pkg::*;
(
  input  logic [HOST_W-1:0] code,
  output op_e               op
);
  // Leading-one position selects the instruction class.
  always_comb begin
    if (code[7])      op = OP_CODE_ADR;
    else if (code[6]) op = OP_PAT_ADR;
    else if (code[5]) op = OP_FUNC;
    else if (code[4]) op = OP_ATTR_ADR;
    else if (code[3]) op = OP_NONE;
    else if (code[2]) op = OP_ENTRY;
    else              op = OP_NONE;
  end
endmodule

// File: rtl/lcdc_addr_step.sv
module lcdc_addr_step
  import lcdc_pkg::*;
#(
  parameter int AW            = 7,
  parameter int PAT_AW        = 6,
  parameter int ATTR_AW       = 4,
  parameter int ONE_LINE_LAST = 'h4F,
  parameter int ROW_LEN       = 40,
  parameter int ROW2_BASE     = 'h40
) (
  input  logic [AW-1:0] cur,
  input  ram_tgt_e      tgt,
  input  logic          up,
  input  logic          two_line,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ROW1_LAST = AW'(ROW_LEN - 1);
  localparam logic [AW-1:0] ROW2_FIRST = AW'(ROW2_BASE);
  localparam logic [AW-1:0] ROW2_LAST = AW'(ROW2_BASE + ROW_LEN - 1);
  localparam logic [AW-1:0] LINE_LAST = AW'(ONE_LINE_LAST);

  logic [PAT_AW-1:0]  pat_nxt;
  logic [ATTR_AW-1:0] attr_nxt;
  logic [AW-1:0]      code_nxt;

  // Narrow memories wrap naturally within their own width.
  assign pat_nxt  = up ? cur[PAT_AW-1:0] + PAT_AW'(1)
                       : cur[PAT_AW-1:0] - PAT_AW'(1);
  assign attr_nxt = up ? cur[ATTR_AW-1:0] + ATTR_AW'(1)
                       : cur[ATTR_AW-1:0] - ATTR_AW'(1);

  always_comb begin
    if (two_line) begin
      if (up)
        code_nxt = (cur == ROW1_LAST) ? ROW2_FIRST :
                   (cur == ROW2_LAST) ? '0 : cur + AW'(1);
      else
        code_nxt = (cur == ROW2_FIRST) ? ROW1_LAST :
                   (cur == '0) ? ROW2_LAST : cur - AW'(1);
    end else begin
      if (up)
        code_nxt = (cur == LINE_LAST) ? '0 : cur + AW'(1);
      else
        code_nxt = (cur == '0) ? LINE_LAST : cur - AW'(1);
    end
  end

  always_comb begin
    case (tgt)
      TGT_PAT:  nxt = AW'(pat_nxt);
      TGT_ATTR: nxt = AW'(attr_nxt);
      default:  nxt = code_nxt;
    endcase
  end
endmodule

// File: rtl/lcdc_busy_timer.sv
module lcdc_busy_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R11
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R11
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/lcdc_cmd_front.sv
module lcdc_cmd_front
  import lcdc_pkg::*;
#(
  parameter int AW            = 7,
  parameter int PAT_AW        = 6,
  parameter int ATTR_AW       = 4,
  parameter int ONE_LINE_LAST = 'h4F,
  parameter int ROW_LEN       = 40,
  parameter int ROW2_BASE     = 'h40,
  parameter int GLYPH_ROWS    = 8,
  parameter int BUSY_CYCLES   = 10,
  parameter int COMW          = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_rs,
  input  logic              host_rw,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [AW:0]       status_rdata,
  output logic              code_we,
  output logic              attr_we,
  output logic              pat_we,
  output logic [AW-1:0]     ram_addr,
  output logic [HOST_W-1:0] ram_wdata,
  output logic              two_line,
  output logic [COMW-1:0]   com_count
);
  localparam logic [AW-1:0] ROW1_LAST  = AW'(ROW_LEN - 1);
  localparam logic [AW-1:0] ROW2_FIRST = AW'(ROW2_BASE);

  logic          busy;
  logic          accept;
  logic          instr_acc;
  logic          data_acc;
  logic [AW-1:0] ac;
  logic [AW-1:0] ac_nxt;
  ram_tgt_e      tgt;
  logic          step_up;
  logic          extra_row;
  op_e           op;

  assign host_ready = 1'b1;
  assign accept     = host_valid && !host_rw && !busy;
  assign instr_acc  = accept && !host_rs;
  assign data_acc   = accept && host_rs;

  lcdc_op_decode u_dec (
    .code (host_wdata),
    .op   (op)
  );

  lcdc_addr_step #(
    .AW            (AW),
    .PAT_AW        (PAT_AW),
    .ATTR_AW       (ATTR_AW),
    .ONE_LINE_LAST (ONE_LINE_LAST),
    .ROW_LEN       (ROW_LEN),
    .ROW2_BASE     (ROW2_BASE)
  ) u_step (
    .cur      (ac),
    .tgt      (tgt),
    .up       (step_up),
    .two_line (two_line),
    .nxt      (ac_nxt)
  );

  lcdc_busy_timer #(
    .CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac        <= '0;
      tgt       <= TGT_CODE;
      step_up   <= 1'b1;
      two_line  <= 1'b0;
      extra_row <= 1'b0;
      code_we   <= 1'b0;
      attr_we   <= 1'b0;
      pat_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      code_we <= 1'b0;
      attr_we <= 1'b0;
      pat_we  <= 1'b0;
      if (data_acc) begin
        ram_addr  <= ac;
        ram_wdata <= host_wdata;
        ac        <= ac_nxt;
        case (tgt)
          TGT_CODE: code_we <= 1'b1;
          TGT_ATTR: attr_we <= 1'b1;
          TGT_PAT:  pat_we  <= 1'b1;
          default:  ;
        endcase
      end
      if (instr_acc) begin
        case (op)
          OP_CODE_ADR: begin
            ac  <= host_wdata[AW-1:0];
            tgt <= TGT_CODE;
          end
          OP_PAT_ADR: begin
            ac  <= AW'(host_wdata[PAT_AW-1:0]);
            tgt <= TGT_PAT;
          end
          OP_ATTR_ADR: begin
            ac  <= AW'(host_wdata[ATTR_AW-1:0]);
            tgt <= TGT_ATTR;
          end
          OP_FUNC: begin
            two_line  <= host_wdata[3];
            extra_row <= host_wdata[2];
          end
          OP_ENTRY: step_up <= host_wdata[1];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    com_count = (two_line ? COMW'(2 * GLYPH_ROWS) : COMW'(GLYPH_ROWS)) + COMW'(extra_row);
  end

  assign status_rdata = {busy, ac};

  // R12
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_rw && busy) |=> !(code_we || attr_we || pat_we));

  // R12
  busy_counter_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_rw && busy) |=> (ac == $past(ac)));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ($countones({code_we, attr_we, pat_we}) == 1)
                 && (ram_wdata == $past(host_wdata)) && (ram_addr == $past(ac)));

  // R2
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_acc && host_wdata[7]) |=> (ac == $past(host_wdata[AW-1:0])) && (tgt == TGT_CODE));

  // R8
  row_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && tgt == TGT_CODE && two_line && step_up && ac == ROW1_LAST)
      |=> (ac == ROW2_FIRST));

  // R9
  pat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && tgt == TGT_PAT && step_up && ac[PAT_AW-1:0] == '1) |=> (ac == '0));
endmodule

// File: tb/test_lcdc_cmd_front.sv
module test_lcdc_cmd_front;
  localparam int BUSY = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_rs = 1'b0;
  logic       host_rw = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] status_rdata;
  logic       code_we, attr_we, pat_we;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       two_line;
  logic [4:0] com_count;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lcdc_cmd_front i_lcdc_cmd_front (
    .clk (clk), .rst_n (rst_n),
    .host_valid (host_valid), .host_ready (host_ready),
    .host_rs (host_rs), .host_rw (host_rw), .host_wdata (host_wdata),
    .status_rdata (status_rdata),
    .code_we (code_we), .attr_we (attr_we), .pat_we (pat_we),
    .ram_addr (ram_addr), .ram_wdata (ram_wdata),
    .two_line (two_line), .com_count (com_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic wr(input bit rs, input logic [7:0] d);
    host_valid = 1'b1; host_rs = rs; host_rw = 1'b0; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic instr(input logic [7:0] d);
    wr(1'b0, d);
    settle();
  endtask

  function automatic int nxt_code(int a, bit two, bit up);
    if (two) begin
      if (up) return (a == 39) ? 64 : (a == 103) ? 0 : a + 1;
      else    return (a == 64) ? 39 : (a == 0) ? 103 : a - 1;
    end
    if (up) return (a == 79) ? 0 : a + 1;
    return (a == 0) ? 79 : a - 1;
  endfunction

  // sel: 4 = code, 2 = attr, 1 = pattern
  task automatic dwrite(input string req, input int sel, input int addr,
                        input logic [7:0] d, input int exp_next);
    wr(1'b1, d);
    chk({req, " strobe"}, {code_we, attr_we, pat_we}, sel);
    chk({req, " addr"}, ram_addr, addr);
    chk({req, " wdata"}, ram_wdata, d);
    settle();
    chk({req, " next counter"}, status_rdata[6:0], exp_next);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", status_rdata, 8'h00);
    chk("R1 com_count", com_count, 8);
    chk("R1 two_line", two_line, 0);
    chk("R1 strobes", {code_we, attr_we, pat_we}, 0);
    chk("R12 ready", host_ready, 1);
    dwrite("R1 default code target up", 4, 0, 8'h3C, 1);

    // R10 function set sweep
    for (int m = 0; m < 4; m++) begin
      instr(8'h20 | 8'((m >> 1) << 3) | 8'((m & 1) << 2));
      chk("R10 com_count", com_count, ((m >> 1) ? 16 : 8) + (m & 1));
      chk("R10 two_line", two_line, m >> 1);
    end
    instr(8'h20);

    // R2 R6 R7 one-line code sweeps
    for (int dir = 1; dir >= 0; dir--) begin
      instr(8'h04 | 8'(dir << 1));
      for (int a = 0; a < 80; a++) begin
        instr(8'h80 | 8'(a));
        chk("R2 load", status_rdata[6:0], a);
        dwrite(dir ? "R7 one-line up" : "R6 R7 one-line down", 4, a, 8'(a ^ 8'h5A),
               nxt_code(a, 1'b0, dir[0]));
      end
    end

    // R8 two-line code sweeps
    instr(8'h28);
    for (int dir = 1; dir >= 0; dir--) begin
      instr(8'h04 | 8'(dir << 1));
      for (int i = 0; i < 80; i++) begin
        int a = (i < 40) ? i : 64 + (i - 40);
        instr(8'h80 | 8'(a));
        dwrite("R8 two-line step", 4, a, 8'(i), nxt_code(a, 1'b1, dir[0]));
      end
    end

    // R3 R9 pattern, R4 R9 attribute sweeps
    for (int dir = 1; dir >= 0; dir--) begin
      instr(8'h04 | 8'(dir << 1));
      for (int a = 0; a < 64; a++) begin
        instr(8'h40 | 8'(a));
        chk("R3 load", status_rdata[6:0], a);
        dwrite("R3 R9 pattern", 1, a, 8'(255 - a), dir ? (a + 1) % 64 : (a + 63) % 64);
      end
      for (int a = 0; a < 16; a++) begin
        instr(8'h10 | 8'(a));
        chk("R4 load", status_rdata[6:0], a);
        dwrite("R4 R9 attribute", 2, a, 8'(a * 3), dir ? (a + 1) % 16 : (a + 15) % 16);
      end
    end

    // R5 target persists across non-address instructions
    instr(8'h06);
    instr(8'h45);
    instr(8'h20);
    instr(8'h06);
    dwrite("R5 pattern persists", 1, 5, 8'hA1, 6);
    dwrite("R5 pattern again", 1, 6, 8'hA2, 7);
    instr(8'h13);
    instr(8'h2C);
    dwrite("R5 attribute persists", 2, 3, 8'hB3, 4);
    instr(8'h20);
    instr(8'h85);

    // R11 busy window, R13 status layout
    wr(1'b1, 8'h77);
    chk("R13 status bits", status_rdata, 8'h86);
    for (int k = 1; k < BUSY; k++) begin
      @(negedge clk);
      chk("R11 busy held", status_rdata[7], 1);
    end
    @(negedge clk);
    chk("R11 busy cleared", status_rdata[7], 0);

    // R12 writes during busy are dropped
    wr(1'b1, 8'h11);
    wr(1'b1, 8'h22);
    chk("R12 no strobe", {code_we, attr_we, pat_we}, 0);
    wr(1'b0, 8'h9F);
    wr(1'b0, 8'h3C);
    wr(1'b0, 8'h04);
    settle();
    chk("R12 counter kept", status_rdata[6:0], 8'h07);
    chk("R12 mode kept", com_count, 8);
    dwrite("R12 target and direction kept", 4, 7, 8'h33, 8);

    // R11 status read does not set busy
    host_valid = 1'b1; host_rs = 1'b0; host_rw = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; host_rw = 1'b0;
    chk("R11 read no busy", status_rdata, 8'h08);

    summary();
    $finish;
  end
endmodule